// File: doc/BRIEF.md
# Multi-Bank Interrupt Control Unit

This block gathers level-sensitive interrupt sources into several banks of 32 and raises one request line per bank toward a processor. Each source that is seen high sets a sticky pending bit. Software services the bank by reading or polling, and clears handled bits by writing ones to the bank's status word. A per-bank enable word gates which pending bits may drive the request. A read-only masked view shows the gated result, and a raw view shows the live inputs. A per-bank index output names the highest-numbered pending and enabled source, which is the one software should service first.

All banks share one simple register bus. The bank windows repeat at a fixed stride, so one bank is addressed by a base plus a small field offset. After reset, software is expected to write 0 to every enable word and all ones to every status word. This clears anything that was latched before the handlers were installed.

Top module: `icu_multibank`

## Requirements
- R1: While reset is asserted and just after it is released, every pending, enable and scratch bit is 0, all `irq_o` and `top_vld_o` bits are low, and `rdata_o` reads 0.
- R2: A source input that is high at a clock edge sets its pending bit, and the bit stays set after the input returns low. The pending bits of bank b read back at field offset 0x00 of that bank.
- R3: Writing a word to the status field (0x00) clears exactly the pending bits written as 1 and leaves the bits written as 0 unchanged. If a source is high in the same cycle as a clear of its bit, the bit remains set.
- R4: The enable field (0x08) is a 32-bit read/write word. The masked field (0x10) reads as pending AND enable.
- R5: `irq_o[b]` is high exactly when the masked value of bank b is nonzero.
- R6: The raw field (0x18) returns the source inputs as they are at the read request edge, without latching.
- R7: The scratch field (0x20) is a 32-bit read/write word, reset to 0, with no effect on requests or pending state.
- R8: Bank b occupies byte addresses b*0x28 up to b*0x28+0x27, and the field offsets above are relative to that base.
- R9: `top_idx_o[5*b +: 5]` gives the bit number of the highest set bit of bank b's masked value, and `top_vld_o[b]` is high when that value is nonzero. Bit 31 is a valid source.
- R10: Any address that is not one of the five field offsets of an existing bank reads 0, and writes to such an address change nothing.
- R11: A read request presents its data on `rdata_o` in the cycle after its edge. The value then holds until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | NUM_BANKS*32 | Level source inputs, bank b at bits [32*b +: 32] |
| req_i | input | 1 | Bus access request, one cycle per access |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| irq_o | output | NUM_BANKS | Per-bank request line |
| top_idx_o | output | NUM_BANKS*5 | Per-bank index of highest pending-and-enabled source |
| top_vld_o | output | NUM_BANKS | Per-bank index valid |

## Verification
The bench tests sticky pending with a single one-cycle pulse. This tells a latching bit apart from a pass-through of the level. Write-one-to-clear is tried with an all-zero word and then a single-bit word, which separates a bitwise clear from a plain overwrite. A collision between a source pulse and an all-ones clear shows whether set wins over clear. Two simultaneous sources at bits 3 and 31 check the index output: after the top one is cleared, the index must move down, which shows the encoder picks the highest bit rather than the lowest. Writes to holes inside a bank window and past the last bank confirm that decoding rejects these addresses.

// File: rtl/icu_pkg.sv
package icu_pkg;
  localparam int unsigned OFS_STAT    = 'h00;
  localparam int unsigned OFS_EN      = 'h08;
  localparam int unsigned OFS_MSTAT   = 'h10;
  localparam int unsigned OFS_RAW     = 'h18;
  localparam int unsigned OFS_MASK    = 'h20;
  localparam int unsigned BANK_STRIDE = 'h28;

  typedef enum logic [2:0] {
    FLD_STAT,
    FLD_EN,
    FLD_MSTAT,
    FLD_RAW,
    FLD_MASK,
    FLD_NONE
  } icu_fld_e;
endpackage

// File: rtl/icu_addr_dec.sv
module icu_addr_dec
  import icu_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8
) (
  input  logic [ADDR_W-1:0]    addr_i,
  output logic [NUM_BANKS-1:0] bank_hit_o,
  output icu_fld_e             fld_o
);
  logic [31:0] addr_ext;
  assign addr_ext = 32'(addr_i);

  always_comb begin
    bank_hit_o = '0;
    fld_o      = FLD_NONE;
    for (int b = 0; b < int'(NUM_BANKS); b++) begin
      if (addr_ext >= 32'(b * BANK_STRIDE) && addr_ext < 32'((b + 1) * BANK_STRIDE)) begin
        case (addr_ext - 32'(b * BANK_STRIDE))
          32'(OFS_STAT):  begin bank_hit_o[b] = 1'b1; fld_o = FLD_STAT;  end
          32'(OFS_EN):    begin bank_hit_o[b] = 1'b1; fld_o = FLD_EN;    end
          32'(OFS_MSTAT): begin bank_hit_o[b] = 1'b1; fld_o = FLD_MSTAT; end
          32'(OFS_RAW):   begin bank_hit_o[b] = 1'b1; fld_o = FLD_RAW;   end
          32'(OFS_MASK):  begin bank_hit_o[b] = 1'b1; fld_o = FLD_MASK;  end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/icu_msb_enc.sv
module icu_msb_enc #(
  parameter int unsigned W = 32,
  localparam int unsigned IW = $clog2(W)
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o,
  output logic          vld_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(W); i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
  assign vld_o = |vec_i;
endmodule

// File: rtl/icu_bank.sv
module icu_bank
  import icu_pkg::*;
#(
  parameter int unsigned SRC_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SRC_W-1:0] src_i,
  input  logic             hit_i,
  input  icu_fld_e         fld_i,
  input  logic             wr_i,
  input  logic [SRC_W-1:0] wdata_i,
  output logic [SRC_W-1:0] pend_o,
  output logic [SRC_W-1:0] en_o,
  output logic [SRC_W-1:0] masked_o,
  output logic [SRC_W-1:0] rdata_o,
  output logic             irq_o
);
  logic [SRC_W-1:0] pend_q, en_q, mask_q, clr;
  logic             wr_hit;

  assign wr_hit = wr_i && hit_i;
  assign clr    = (wr_hit && fld_i == FLD_STAT) ? wdata_i : '0;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q <= '0;
      en_q   <= '0;
      mask_q <= '0;
    end else begin
      // source set dominates a same-cycle clear
      pend_q <= (pend_q & ~clr) | src_i;
      if (wr_hit && fld_i == FLD_EN)   en_q   <= wdata_i;
      if (wr_hit && fld_i == FLD_MASK) mask_q <= wdata_i;
    end
  end

  assign masked_o = pend_q & en_q;
  assign irq_o    = |masked_o;
  assign pend_o   = pend_q;
  assign en_o     = en_q;

  always_comb begin
    rdata_o = '0;
    if (hit_i) begin
      case (fld_i)
        FLD_STAT:  rdata_o = pend_q;
        FLD_EN:    rdata_o = en_q;
        FLD_MSTAT: rdata_o = masked_o;
        FLD_RAW:   rdata_o = src_i;
        FLD_MASK:  rdata_o = mask_q;
        default:   rdata_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/icu_multibank.sv
module icu_multibank
  import icu_pkg::*;
#(
  parameter int unsigned NUM_BANKS = 5,
  parameter int unsigned ADDR_W    = 8,
  localparam int unsigned SRC_W = 32,
  localparam int unsigned IW    = $clog2(SRC_W)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_BANKS*SRC_W-1:0] src_i,
  input  logic                      req_i,
  input  logic                      we_i,
  input  logic [ADDR_W-1:0]         addr_i,
  input  logic [SRC_W-1:0]          wdata_i,
  output logic [SRC_W-1:0]          rdata_o,
  output logic [NUM_BANKS-1:0]      irq_o,
  output logic [NUM_BANKS*IW-1:0]   top_idx_o,
  output logic [NUM_BANKS-1:0]      top_vld_o
);
  logic [NUM_BANKS-1:0]       bank_hit;
  icu_fld_e                   fld;
  logic [NUM_BANKS*SRC_W-1:0] pend_w, en_w, masked_w, bank_rd;
  logic [SRC_W-1:0]           rd_mux, rdata_q;

  icu_addr_dec #(.NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W)) i_dec (
    .addr_i     (addr_i),
    .bank_hit_o (bank_hit),
    .fld_o      (fld)
  );

  for (genvar b = 0; b < int'(NUM_BANKS); b++) begin : g_bank
    icu_bank #(.SRC_W(SRC_W)) i_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[b*SRC_W +: SRC_W]),
      .hit_i    (bank_hit[b]),
      .fld_i    (fld),
      .wr_i     (req_i && we_i),
      .wdata_i  (wdata_i),
      .pend_o   (pend_w[b*SRC_W +: SRC_W]),
      .en_o     (en_w[b*SRC_W +: SRC_W]),
      .masked_o (masked_w[b*SRC_W +: SRC_W]),
      .rdata_o  (bank_rd[b*SRC_W +: SRC_W]),
      .irq_o    (irq_o[b])
    );

    icu_msb_enc #(.W(SRC_W)) i_enc (
      .vec_i (masked_w[b*SRC_W +: SRC_W]),
      .idx_o (top_idx_o[b*IW +: IW]),
      .vld_o (top_vld_o[b])
    );
  end

  // non-selected banks return zero, so OR merges them
  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < int'(NUM_BANKS); b++) rd_mux |= bank_rd[b*SRC_W +: SRC_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (req_i && !we_i)  rdata_q <= rd_mux;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/icu_multibank_chk.sv
module icu_multibank_chk #(
  parameter int unsigned NB    = 5,
  parameter int unsigned SRC_W = 32,
  localparam int unsigned IW   = $clog2(SRC_W)
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  req_i,
  input logic                  we_i,
  input logic [NB*SRC_W-1:0]   src_i,
  input logic [NB*SRC_W-1:0]   pend_w,
  input logic [NB*SRC_W-1:0]   en_w,
  input logic [NB-1:0]         irq_o,
  input logic [NB-1:0]         top_vld_o,
  input logic [NB*IW-1:0]      top_idx_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk_i) !rst_ni |-> (irq_o == '0 && top_vld_o == '0));

  // R2
  pend_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|src_i) |=> ((pend_w & $past(src_i)) == $past(src_i)));

  // R3
  pend_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_i && we_i) |=> ((pend_w & $past(pend_w)) == $past(pend_w)));

  // R5
  vld_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) top_vld_o == irq_o);

  for (genvar b = 0; b < int'(NB); b++) begin : g_b
    logic [SRC_W-1:0] m;
    assign m = pend_w[b*SRC_W +: SRC_W] & en_w[b*SRC_W +: SRC_W];
    // R9
    idx_top_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      top_vld_o[b] |-> ((m >> top_idx_o[b*IW +: IW]) == SRC_W'(1)));
  end
endmodule

bind icu_multibank icu_multibank_chk #(.NB(NUM_BANKS), .SRC_W(SRC_W)) i_icu_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .req_i     (req_i),
  .we_i      (we_i),
  .src_i     (src_i),
  .pend_w    (pend_w),
  .en_w      (en_w),
  .irq_o     (irq_o),
  .top_vld_o (top_vld_o),
  .top_idx_o (top_idx_o)
);

// File: tb/test_icu_multibank.sv
module test_icu_multibank;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;
  localparam int AW = 8;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic [NB*32-1:0] src_i = '0;
  logic            req_i = 1'b0, we_i = 1'b0;
  logic [AW-1:0]   addr_i = '0;
  logic [31:0]     wdata_i = '0;
  logic [31:0]     rdata_o;
  logic [NB-1:0]   irq_o, top_vld_o;
  logic [NB*5-1:0] top_idx_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  icu_multibank #(.NUM_BANKS(NB), .ADDR_W(AW)) i_icu_multibank (
    .clk_i, .rst_ni, .src_i, .req_i, .we_i, .addr_i, .wdata_i,
    .rdata_o, .irq_o, .top_idx_o, .top_vld_o
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    req_i = 0; we_i = 0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk_i);
    req_i = 1; we_i = 0; addr_i = a;
    @(negedge clk_i);
    req_i = 0;
    d = rdata_o;
  endtask

  task automatic pulse(int b, int bitn);
    @(negedge clk_i);
    src_i[b*32 + bitn] = 1'b1;
    @(negedge clk_i);
    src_i[b*32 + bitn] = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq_o), 0);
    check("R1 vld", 32'(top_vld_o), 0);
    check("R1 rdata", rdata_o, 0);
    rd(8'h08, d); check("R1 enable", d, 0);
    rd(8'h20, d); check("R1 scratch", d, 0);
  endtask

  task automatic t_sticky();
    logic [31:0] d;
    pulse(1, 5);
    rd(8'h28, d); check("R2 R8 sticky", d, 32'h20);
    check("R5 gated off", 32'(irq_o), 0);
  endtask

  task automatic t_enable();
    logic [31:0] d;
    wr(8'h30, 32'h20);
    rd(8'h30, d); check("R4 enable rw", d, 32'h20);
    rd(8'h38, d); check("R4 masked", d, 32'h20);
    check("R5 irq on", 32'(irq_o), 32'h2);
    check("R9 idx", 32'(top_idx_o[5 +: 5]), 5);
  endtask

  task automatic t_w1c();
    logic [31:0] d;
    wr(8'h28, 32'h0);
    rd(8'h28, d); check("R3 zero keeps", d, 32'h20);
    wr(8'h28, 32'h20);
    rd(8'h28, d); check("R3 one clears", d, 0);
    check("R5 irq off", 32'(irq_o), 0);
  endtask

  task automatic t_collide_and_idx();
    logic [31:0] d;
    wr(8'h58, 32'hFFFF_FFFF);
    @(negedge clk_i);
    src_i[2*32 + 31] = 1; req_i = 1; we_i = 1; addr_i = 8'h50; wdata_i = '1;
    @(negedge clk_i);
    src_i[2*32 + 31] = 0; req_i = 0; we_i = 0;
    rd(8'h50, d); check("R3 set beats clear", d, 32'h8000_0000);
    @(negedge clk_i);
    src_i[2*32 + 3] = 1;
    @(negedge clk_i);
    src_i[2*32 + 3] = 0;
    check("R9 idx 31", 32'(top_idx_o[10 +: 5]), 31);
    check("R9 vld", 32'(top_vld_o), 32'h4);
    wr(8'h50, 32'h8000_0000);
    check("R9 idx falls to 3", 32'(top_idx_o[10 +: 5]), 3);
    wr(8'h50, 32'h8);
    check("R9 vld clear", 32'(top_vld_o), 0);
  endtask

  task automatic t_raw_hold();
    logic [31:0] d;
    @(negedge clk_i);
    src_i[3*32 +: 32] = 32'hA5C3_0F01;
    rd(8'h90, d); check("R6 raw", d, 32'hA5C3_0F01);
    src_i[3*32 +: 32] = 32'h0;
    @(negedge clk_i);
    @(negedge clk_i);
    check("R11 hold", rdata_o, 32'hA5C3_0F01);
    wr(8'h78, '1);
  endtask

  task automatic t_scratch();
    logic [31:0] d;
    wr(8'hC0, 32'hDEAD_BEEF);
    rd(8'hC0, d); check("R7 scratch rw", d, 32'hDEAD_BEEF);
    check("R7 no irq", 32'(irq_o), 0);
    rd(8'hA0, d); check("R7 no pend", d, 0);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    wr(8'h24, '1);
    wr(8'h04, '1);
    wr(8'hC8, '1);
    rd(8'h20, d); check("R10 bank0 scratch", d, 0);
    rd(8'h08, d); check("R10 bank0 enable", d, 0);
    rd(8'h30, d); check("R10 bank1 enable", d, 32'h20);
    rd(8'h24, d); check("R10 hole read", d, 0);
    rd(8'hC8, d); check("R10 past end", d, 0);
    rd(8'hFF, d); check("R10 top addr", d, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected done");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_sticky();
    t_enable();
    t_w1c();
    t_collide_and_idx();
    t_raw_hold();
    t_scratch();
    t_unmapped();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule